// File: doc/BRIEF.md
# Fractional-Nanosecond Time-of-Day Counter

This block keeps a free-running time-of-day value for IEEE 1588 timestamping. It holds a 64-bit count of whole nanoseconds and a 32-bit binary fraction of a nanosecond. On every core clock cycle in which the run bit is set, it adds a programmable step. The step is a 32.32 fixed-point nanosecond value, so the step for a core clock of rate F is floor(2^32 x 10^9 / F). For example, an 800 MHz clock takes 0x0000_0001_4000_0000, which is 1.25 ns. Software trims the clock frequency by rewriting the step while the counter runs. The current whole-nanosecond value is driven out on a timestamp port for neighbouring blocks.

Software reaches the block through a small 64-bit register bus. Each request lasts one cycle and carries an address, a write flag and write data. A read answers one cycle later with a valid strobe and the data. Four registers are mapped: control, fraction, whole nanoseconds and step. Reading the fraction captures the whole-nanosecond word into a holding register, so that a following whole-nanosecond read forms a coherent snapshot with it.

Top module: `ptp_time_counter`

## Requirements
- R1: After a synchronous active-low reset, every register reads zero, `ts_ns` is zero and `rsp_valid` is low.
- R2: Bit 0 of the control register at offset 0xF00 is the run bit. The time value advances only while it is 1, and clearing it freezes the time value.
- R3: While running, each cycle adds the 64-bit step at offset 0xF18 to the 96-bit value {nanoseconds, fraction}. Bits 63:32 of the step are whole ns and bits 31:0 are the fraction. A carry out of the fraction enters the nanosecond word, and the nanosecond word wraps modulo 2^64.
- R4: A write to the step register is used from the following cycle onward. The cycle of the write still adds the old step, and the time value is not disturbed.
- R5: A write to offset 0xF10 loads the whole-nanosecond word. A write to 0xF08 loads the fraction from write data bits 31:0. In the cycle of either write, no step is added, even while running.
- R6: A read request is answered exactly one cycle later with `rsp_valid` high, and the data reflects register contents in the request cycle. A write request produces no response.
- R7: A read of 0xF08 returns the fraction in bits 31:0 with zero above it, and captures the whole-nanosecond word. The next read of 0xF10 returns the captured value and consumes it. A read of 0xF10 with no capture pending returns the live word.
- R8: The control register stores and returns all 64 written bits.
- R9: A read of any other offset returns zero, and a write to any other offset changes no register.
- R10: `ts_ns` always presents the current whole-nanosecond word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Register request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte offset of the register |
| req_wdata | input | 64 | Write data |
| rsp_valid | output | 1 | Read data valid (one cycle after a read request) |
| rsp_rdata | output | 64 | Read data |
| ts_ns | output | 64 | Current whole-nanosecond time |

## Verification
The bench checks fractional carries that land on an exact step boundary, nanosecond wraparound past 2^64, and a zero step. A design that dropped the carry, or summed only the integer parts, would show the fraction or the nanosecond word off by one step. The bench rewrites the step mid-run and loads the time words while running. A design that applied the new step in its write cycle, or added a step on top of a load, would be off by the step difference or by one step. The bench also checks the capture of the whole-nanosecond word on a fraction read, including a load between the two reads and a second read after the capture has been consumed. A design without the capture would return a torn or stale pair. Unmapped offsets and a reset in mid-run complete the set.

// File: rtl/ptp_tc_pkg.sv
// Shared definitions for the time-of-day counter: register offsets and the
// register-select type produced by the address decoder.
// Assumes byte offsets fit in the address width of the instantiating block.
package ptp_tc_pkg;

    localparam int unsigned OFF_CTRL = 32'h0000_0F00;
    localparam int unsigned OFF_FRAC = 32'h0000_0F08;
    localparam int unsigned OFF_NS   = 32'h0000_0F10;
    localparam int unsigned OFF_STEP = 32'h0000_0F18;

    typedef enum logic [2:0] {
        SEL_NONE = 3'd0,
        SEL_CTRL = 3'd1,
        SEL_FRAC = 3'd2,
        SEL_NS   = 3'd3,
        SEL_STEP = 3'd4
    } reg_sel_e;

endpackage

// File: rtl/ptp_tc_regdec.sv
// Address decoder: maps a request byte offset onto one of the four registers,
// or SEL_NONE for any unmapped offset. Purely combinational.
module ptp_tc_regdec
    import ptp_tc_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel
);

    // Compare the offset against each mapped register.
    always_comb begin
        if (addr == ADDR_W'(OFF_CTRL))      sel = SEL_CTRL;
        else if (addr == ADDR_W'(OFF_FRAC)) sel = SEL_FRAC;
        else if (addr == ADDR_W'(OFF_NS))   sel = SEL_NS;
        else if (addr == ADDR_W'(OFF_STEP)) sel = SEL_STEP;
        else                                sel = SEL_NONE;
    end

endmodule

// File: rtl/ptp_tc_accum.sv
// Time accumulator: holds whole nanoseconds and a binary fraction. While
// enabled it adds the fixed-point step every cycle, with the fraction carry
// rippling into the nanosecond word and the total wrapping modulo 2^(NS_W+FRAC_W).
// A load of either word wins over that cycle's step; the other word holds.
// Assumes NS_W >= FRAC_W and that the step is no wider than the accumulator.
module ptp_tc_accum #(
    parameter int NS_W   = 64,
    parameter int FRAC_W = 32,
    parameter int STEP_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_en,
    input  logic              ld_ns,
    input  logic              ld_frac,
    input  logic [NS_W-1:0]   ld_val,
    input  logic [STEP_W-1:0] step,
    output logic [NS_W-1:0]   ns_q,
    output logic [FRAC_W-1:0] frac_q
);

    localparam int ACC_W = NS_W + FRAC_W;

    logic [ACC_W-1:0] acc_now;
    logic [ACC_W-1:0] acc_next;

    // Join both words and add the zero-extended step.
    always_comb begin
        acc_now  = {ns_q, frac_q};
        acc_next = acc_now + ACC_W'(step);
    end

    // Update time: reset, then loads, then the per-cycle step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ns_q   <= '0;
            frac_q <= '0;
        end else if (ld_ns || ld_frac) begin
            if (ld_ns)   ns_q   <= ld_val;
            if (ld_frac) frac_q <= ld_val[FRAC_W-1:0];
        end else if (run_en) begin
            ns_q   <= acc_next[ACC_W-1:FRAC_W];
            frac_q <= acc_next[FRAC_W-1:0];
        end
    end

endmodule

// File: rtl/ptp_tc_rdport.sv
// Read port: selects the addressed register, registers the answer one cycle
// after the request, and keeps the nanosecond capture taken on a fraction
// read. The capture is consumed by the next nanosecond read; without a
// pending capture a nanosecond read returns the live word.
// Assumes DATA_W is at least as wide as every register it returns.
module ptp_tc_rdport
    import ptp_tc_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int NS_W   = 64,
    parameter int FRAC_W = 32,
    parameter int STEP_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_req,
    input  reg_sel_e          sel,
    input  logic [DATA_W-1:0] ctrl_q,
    input  logic [FRAC_W-1:0] frac_q,
    input  logic [NS_W-1:0]   ns_q,
    input  logic [STEP_W-1:0] step_q,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata
);

    logic [NS_W-1:0]   cap_q;
    logic              cap_pend_q;
    logic [DATA_W-1:0] rd_val;

    // Pick the value of the addressed register.
    always_comb begin
        unique case (sel)
            SEL_CTRL: rd_val = ctrl_q;
            SEL_FRAC: rd_val = DATA_W'(frac_q);
            SEL_NS:   rd_val = cap_pend_q ? DATA_W'(cap_q) : DATA_W'(ns_q);
            SEL_STEP: rd_val = DATA_W'(step_q);
            default:  rd_val = '0;
        endcase
    end

    // Register the response one cycle after the read request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= rd_req;
            rsp_rdata <= rd_req ? rd_val : '0;
        end
    end

    // Capture the nanosecond word on a fraction read; consume on a ns read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_q      <= '0;
            cap_pend_q <= 1'b0;
        end else if (rd_req && sel == SEL_FRAC) begin
            cap_q      <= ns_q;
            cap_pend_q <= 1'b1;
        end else if (rd_req && sel == SEL_NS) begin
            cap_pend_q <= 1'b0;
        end
    end

endmodule

// File: rtl/ptp_time_counter.sv
// Top of the time-of-day counter. Holds the control and step registers,
// decodes single-cycle register requests, and connects the accumulator and
// the read port. Bit 0 of the control register gates the per-cycle step.
// Assumes one request per cycle at most and a synchronous active-low reset.
module ptp_time_counter
    import ptp_tc_pkg::*;
#(
    parameter int ADDR_W   = 12,
    parameter int DATA_W   = 64,
    parameter int NS_W     = 64,
    parameter int FRAC_W   = 32,
    parameter int STEP_INT = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [NS_W-1:0]   ts_ns
);

    localparam int STEP_W = STEP_INT + FRAC_W;

    reg_sel_e          sel;
    logic              wr_req;
    logic              rd_req;
    logic [DATA_W-1:0] ctrl_q;
    logic [STEP_W-1:0] step_q;
    logic              run_en;
    logic [NS_W-1:0]   ns_q;
    logic [FRAC_W-1:0] frac_q;
    logic              ld_ns;
    logic              ld_frac;

    // Split the request into read and write strobes.
    always_comb begin
        wr_req  = req_valid && req_write;
        rd_req  = req_valid && !req_write;
        ld_ns   = wr_req && (sel == SEL_NS);
        ld_frac = wr_req && (sel == SEL_FRAC);
        run_en  = ctrl_q[0];
    end

    ptp_tc_regdec #(.ADDR_W(ADDR_W)) u_dec (
        .addr (req_addr),
        .sel  (sel)
    );

    // Control and step registers: reset to zero, loaded by writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            step_q <= '0;
        end else if (wr_req) begin
            if (sel == SEL_CTRL) ctrl_q <= req_wdata;
            if (sel == SEL_STEP) step_q <= req_wdata[STEP_W-1:0];
        end
    end

    ptp_tc_accum #(
        .NS_W   (NS_W),
        .FRAC_W (FRAC_W),
        .STEP_W (STEP_W)
    ) u_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_en  (run_en),
        .ld_ns   (ld_ns),
        .ld_frac (ld_frac),
        .ld_val  (req_wdata[NS_W-1:0]),
        .step    (step_q),
        .ns_q    (ns_q),
        .frac_q  (frac_q)
    );

    ptp_tc_rdport #(
        .DATA_W (DATA_W),
        .NS_W   (NS_W),
        .FRAC_W (FRAC_W),
        .STEP_W (STEP_W)
    ) u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_req    (rd_req),
        .sel       (sel),
        .ctrl_q    (ctrl_q),
        .frac_q    (frac_q),
        .ns_q      (ns_q),
        .step_q    (step_q),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata)
    );

    assign ts_ns = ns_q;

endmodule

// File: rtl/ptp_time_counter_chk.sv
// Property checker for the time-of-day counter, attached by bind.
// Watches the register bus, the timestamp port, the run bit and the step.
module ptp_time_counter_chk #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 64,
    parameter int NS_W   = 64,
    parameter int FRAC_W = 32,
    parameter int STEP_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic [DATA_W-1:0] req_wdata,
    input logic              rsp_valid,
    input logic [DATA_W-1:0] rsp_rdata,
    input logic [NS_W-1:0]   ts_ns,
    input logic              run_en,
    input logic [STEP_W-1:0] step_q
);

    logic [NS_W-1:0] step_whole;
    logic            mapped;
    logic            any_wr;
    logic            any_rd;

    // Derive bus qualifiers and the whole-ns part of the step.
    always_comb begin
        step_whole = NS_W'(step_q >> FRAC_W);
        any_wr     = req_valid && req_write;
        any_rd     = req_valid && !req_write;
        mapped     = (req_addr == ADDR_W'(32'hF00)) || (req_addr == ADDR_W'(32'hF08)) ||
                     (req_addr == ADDR_W'(32'hF10)) || (req_addr == ADDR_W'(32'hF18));
    end

    // R1: reset clears the timestamp and the response strobe
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (ts_ns == '0 && !rsp_valid));

    // R2: without the run bit and without a write, time stays frozen
    assert_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_en && !any_wr) |=> $stable(ts_ns));

    // R3: while running, ns advances by the whole step or one more (carry)
    assert_step_advance_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && !any_wr) |=>
            ((ts_ns - $past(ts_ns)) == $past(step_whole)) ||
            ((ts_ns - $past(ts_ns)) == $past(step_whole) + NS_W'(1)));

    // R5: a ns write loads the word with no step on top
    assert_ns_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (any_wr && req_addr == ADDR_W'(32'hF10)) |=> (ts_ns == $past(req_wdata[NS_W-1:0])));

    // R6: a read is answered on the next cycle
    assert_read_answer_R6: assert property (@(posedge clk) disable iff (!rst_n)
        any_rd |=> rsp_valid);

    // R6: no response without a read
    assert_no_spurious_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !any_rd |=> !rsp_valid);

    // R9: unmapped reads return zero
    assert_unmapped_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (any_rd && !mapped) |=> (rsp_rdata == '0));

endmodule

bind ptp_time_counter ptp_time_counter_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .NS_W   (NS_W),
    .FRAC_W (FRAC_W),
    .STEP_W (STEP_INT + FRAC_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .ts_ns     (ts_ns),
    .run_en    (run_en),
    .step_q    (step_q)
);

// File: tb/ptp_time_counter_test.sv
// Self-checking bench: a vector table of start time, step and run length,
// followed by directed tests for reset, bus timing, capture and corner cases.
module ptp_time_counter_test;

    localparam int CLK_PERIOD = 10;
    localparam logic [11:0] A_CTRL = 12'hF00;
    localparam logic [11:0] A_FRAC = 12'hF08;
    localparam logic [11:0] A_NS   = 12'hF10;
    localparam logic [11:0] A_STEP = 12'hF18;

    typedef struct packed {
        logic [63:0] t0;
        logic [31:0] f0;
        logic [63:0] step;
        logic [15:0] run_n;
    } vec_t;

    localparam int NVEC = 5;
    localparam vec_t VECS [NVEC] = '{
        '{64'd0,                    32'h0000_0000, 64'h0000_0001_4000_0000, 16'd20},
        '{64'd1000,                 32'hFFFF_FFF0, 64'h0000_0000_0000_0010, 16'd0},
        '{64'hFFFF_FFFF_FFFF_FFFA,  32'h0000_0000, 64'h0000_0002_0000_0000, 16'd5},
        '{64'd12345,                32'h8000_0000, 64'h0000_0000_0000_0000, 16'd7},
        '{64'd5,                    32'h1234_5678, 64'h0000_0003_9ABC_DEF0, 16'd33}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [11:0] req_addr = '0;
    logic [63:0] req_wdata = '0;
    logic        rsp_valid;
    logic [63:0] rsp_rdata;
    logic [63:0] ts_ns;

    int n_chk = 0;
    int n_fail = 0;
    int n_edge = 0;
    int e_last = 0;
    int r_last = 0;
    logic rsp_seen = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ptp_time_counter uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata),
        .ts_ns     (ts_ns)
    );

    task automatic tick();
        @(posedge clk);
        #1;
        n_edge++;
    endtask

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [63:0] d);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        tick();
        e_last = n_edge;
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [63:0] d);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        tick();
        r_last = n_edge;
        d = rsp_rdata;
        rsp_seen = rsp_valid;
        req_valid = 1'b0;
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        logic [63:0] lo, hi, v0, v1, v2, v3;
        logic [95:0] acc_e;
        int e, r, d, w, h;

        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R1: reset state
        chk("R1 ts_ns after reset", ts_ns, 64'd0);
        chk("R1 rsp_valid after reset", {63'd0, rsp_valid}, 64'd0);
        rd(A_CTRL, v0); chk("R1 ctrl reset", v0, 64'd0);
        rd(A_FRAC, v0); chk("R1 frac reset", v0, 64'd0);
        rd(A_NS,   v0); chk("R1 ns reset", v0, 64'd0);
        rd(A_STEP, v0); chk("R1 step reset", v0, 64'd0);

        // R6: response timing
        rd(A_CTRL, v0);
        chk("R6 rsp_valid one cycle after read", {63'd0, rsp_seen}, 64'd1);
        tick();
        chk("R6 rsp_valid low when idle", {63'd0, rsp_valid}, 64'd0);
        wr(A_STEP, 64'd7);
        chk("R6 no response to write", {63'd0, rsp_valid}, 64'd0);

        // R3 R7 R10 R2: vector table walk
        for (int i = 0; i < NVEC; i++) begin
            wr(A_CTRL, 64'd0);
            wr(A_NS, VECS[i].t0);
            wr(A_FRAC, {32'd0, VECS[i].f0});
            wr(A_STEP, VECS[i].step);
            wr(A_CTRL, 64'd1);
            e = e_last;
            repeat (int'(VECS[i].run_n)) tick();
            rd(A_FRAC, lo);
            r = r_last;
            rd(A_NS, hi);
            acc_e = {VECS[i].t0, VECS[i].f0} + 96'(r - 1 - e) * 96'(VECS[i].step);
            chk("R3 R7 fraction after run", lo, {32'd0, acc_e[31:0]});
            chk("R3 R7 nanoseconds after run", hi, acc_e[95:32]);
            wr(A_CTRL, 64'd0);
            d = e_last;
            tick(); tick();
            acc_e = {VECS[i].t0, VECS[i].f0} + 96'(d - e) * 96'(VECS[i].step);
            chk("R2 R10 frozen ts_ns", ts_ns, acc_e[95:32]);
        end

        // R8: control keeps all bits; bit 0 clear keeps time frozen
        v1 = ts_ns;
        wr(A_CTRL, 64'hA5A5_0000_0000_1230);
        rd(A_CTRL, v0);
        chk("R8 control readback", v0, 64'hA5A5_0000_0000_1230);
        repeat (4) tick();
        chk("R2 frozen with bit0 clear", ts_ns, v1);

        // R9: unmapped offsets
        rd(A_CTRL, v0); rd(A_FRAC, v1); rd(A_NS, v2); rd(A_STEP, v3);
        wr(12'hF20, 64'hFFFF_FFFF_FFFF_FFFF);
        wr(12'h000, 64'hFFFF_FFFF_FFFF_FFFF);
        wr(12'hF0C, 64'hFFFF_FFFF_FFFF_FFFF);
        rd(12'hF04, lo); chk("R9 unmapped read F04", lo, 64'd0);
        rd(12'h008, lo); chk("R9 unmapped read 008", lo, 64'd0);
        rd(A_CTRL, lo);  chk("R9 ctrl untouched", lo, v0);
        rd(A_FRAC, lo);  chk("R9 frac untouched", lo, v1);
        rd(A_NS, lo);    chk("R9 ns untouched", lo, v2);
        rd(A_STEP, lo);  chk("R9 step untouched", lo, v3);

        // R4: step rewrite while running
        wr(A_CTRL, 64'd0);
        wr(A_NS, 64'd100);
        wr(A_FRAC, 64'd0);
        wr(A_STEP, 64'h0000_0001_0000_0000);
        wr(A_CTRL, 64'd1);
        e = e_last;
        repeat (4) tick();
        wr(A_STEP, 64'h0000_0003_0000_0000);
        w = e_last;
        repeat (3) tick();
        rd(A_FRAC, lo);
        r = r_last;
        rd(A_NS, hi);
        chk("R4 ns after step change", hi, 64'(100 + (w - e) + 3 * (r - 1 - w)));
        chk("R4 fraction undisturbed", lo, 64'd0);

        // R5: loads win over the step while running
        wr(A_NS, 64'd5000);
        h = e_last;
        repeat (2) tick();
        rd(A_FRAC, lo);
        r = r_last;
        rd(A_NS, hi);
        chk("R5 ns load while running", hi, 64'(5000 + 3 * (r - 1 - h)));
        wr(A_FRAC, 64'hFFFF_FFFF_4000_0000);
        rd(A_FRAC, lo);
        rd(A_NS, hi);
        chk("R5 fraction load uses bits 31:0", lo, 64'h0000_0000_4000_0000);
        wr(A_CTRL, 64'd0);

        // R7: capture survives a later load, then is consumed
        wr(A_NS, 64'd777);
        rd(A_FRAC, lo);
        wr(A_NS, 64'd888);
        rd(A_NS, hi);
        chk("R7 ns read returns capture", hi, 64'd777);
        rd(A_NS, hi);
        chk("R7 ns read after consume is live", hi, 64'd888);
        chk("R10 ts_ns shows live ns", ts_ns, 64'd888);

        // R1: reset in mid-run
        wr(A_STEP, 64'h0000_0002_0000_0000);
        wr(A_CTRL, 64'd1);
        repeat (3) tick();
        rst_n = 1'b0;
        tick();
        rst_n = 1'b1;
        chk("R1 ts_ns after mid-run reset", ts_ns, 64'd0);
        rd(A_CTRL, v0); chk("R1 ctrl after mid-run reset", v0, 64'd0);
        rd(A_STEP, v0); chk("R1 step after mid-run reset", v0, 64'd0);
        repeat (3) tick();
        chk("R1 R2 stays frozen after reset", ts_ns, 64'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule